// File: doc/BRIEF.md
# Register-Controlled Watchdog Timer Core

This block is a watchdog timer controlled through a small register file addressed by byte. A plain write strobe with an address and a data byte programs it, and a combinational read port returns the addressed byte. A serial target front end would normally drive this port. The core keeps a three-valued run state, a timeout in whole seconds, a countdown of the seconds that remain, a ping register that restarts the countdown, a reset-pulse width in milliseconds, and a code for the cause of the last reset it issued.

A one-millisecond tick input sets the time base. A prescaler turns `TICKS_PER_SEC` ticks into one second. The core starts in an unconfigured state and does not count until software switches it on. Once it is on, software must ping it before the countdown runs out. If the countdown runs out, the core drives its reset output for the programmed number of ticks, records the expiry as the cause, and starts counting again. A host request input fires the same pulse with a separate cause code.

Top module: `wdog_regfile_core`

## Requirements
- R1: After reset the state register reads 0x00 (unconfigured), the timeout reads `DEF_TIMEOUT`, the time-left reads `DEF_TIMEOUT`, the pulse width reads `DEF_PULSE_MS`, the cause code reads 0x00 (power cycle), and `rst_out` is low.
- R2: The state register sits at address 0x06. A written 0x01 (off) or 0x02 (on) is taken and every other value is ignored. The countdown advances only while the state is 0x02.
- R3: The timeout register sits at address 0x07. A written value from 3 to 255 is taken and a smaller one is ignored. A new value does not change a countdown already running, and it takes effect at the next reload.
- R4: The read-only time-left register sits at address 0x08, and writes to it are ignored. A change of state into on reloads it from the timeout. It drops by one every `TICKS_PER_SEC` ticks while on, and it never reads 0.
- R5: Writing 0x00 to address 0x09 while the state is on reloads the countdown from the timeout and restarts the second prescaler. A nonzero ping value, or any ping while the state is not on, has no effect.
- R6: If the countdown is at 1 when a second ends in the on state, the core expires. The cause code becomes 0x01, the reset pulse starts, and the countdown reloads from the timeout.
- R7: The pulse-width register sits at address 0x0A. A written value from 1 to 255 is taken and 0 is ignored. `rst_out` rises in the cycle after the pulse starts and stays high for exactly the programmed number of ticks that follow.
- R8: A `host_req` cycle starts the reset pulse and sets the cause code to 0x04. If an expiry happens in the same cycle, code 0x01 wins.
- R9: The cause code reads at address 0x05. Every address without a register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| host_req | input | 1 | Host-requested reset pulse |
| rst_out | output | 1 | Reset pulse output, active high |

## Verification
The bench builds the core with `TICKS_PER_SEC` = 4, `DEF_TIMEOUT` = 5 and `DEF_PULSE_MS` = 3, and it issues a tick every third clock. With these values a full countdown to expiry takes a few dozen cycles. Several expiries, pulses of different widths, pings in each state and the timeout boundary values therefore all fit in a short run. A behavioural model predicts `rst_out` and the byte at the addressed register on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [7:0] {
        ST_INIT = 8'h00,
        ST_OFF  = 8'h01,
        ST_ON   = 8'h02
    } run_state_e;

    localparam logic [7:0] ADR_CAUSE = 8'h05;
    localparam logic [7:0] ADR_STATE = 8'h06;
    localparam logic [7:0] ADR_TMO   = 8'h07;
    localparam logic [7:0] ADR_LEFT  = 8'h08;
    localparam logic [7:0] ADR_PING  = 8'h09;
    localparam logic [7:0] ADR_WIDTH = 8'h0A;

    localparam logic [7:0] CAUSE_POWER  = 8'h00;
    localparam logic [7:0] CAUSE_EXPIRY = 8'h01;
    localparam logic [7:0] CAUSE_HOST   = 8'h04;

    localparam logic [7:0] TMO_MIN  = 8'd3;
    localparam logic [7:0] PING_KEY = 8'h00;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic tmo_ok(input logic [7:0] v);
        return v >= TMO_MIN;
    endfunction

    function automatic logic width_ok(input logic [7:0] v);
        return v != 8'h00;
    endfunction

    function automatic logic state_ok(input logic [7:0] v);
        return (v == ST_OFF) || (v == ST_ON);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [7:0] DEF_TMO   = 8'd30,
    parameter logic [7:0] DEF_WIDTH = 8'd100
) (
    input  logic       clk,
    input  logic       rst,
    input  reg_wr_t    wr,
    output run_state_e state_q,
    output logic [7:0] tmo_q,
    output logic [7:0] width_q,
    output logic       reload
);
    logic hit_state, hit_tmo, hit_width, hit_ping;

    always_comb begin
        hit_state = wr.wr && (wr.addr == ADR_STATE);
        hit_tmo   = wr.wr && (wr.addr == ADR_TMO);
        hit_width = wr.wr && (wr.addr == ADR_WIDTH);
        hit_ping  = wr.wr && (wr.addr == ADR_PING);
        reload    = (hit_state && (wr.data == ST_ON) && (state_q != ST_ON)) ||
                    (hit_ping && (wr.data == PING_KEY) && (state_q == ST_ON));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            tmo_q   <= DEF_TMO;
            width_q <= DEF_WIDTH;
        end else begin
            if (hit_state && state_ok(wr.data)) state_q <= run_state_e'(wr.data);
            if (hit_tmo && tmo_ok(wr.data))     tmo_q   <= wr.data;
            if (hit_width && width_ok(wr.data)) width_q <= wr.data;
        end
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int         TICKS_PER_SEC = 1000,
    parameter logic [7:0] DEF_TMO       = 8'd30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       reload,
    input  logic       tick,
    input  logic [7:0] tmo,
    output logic [7:0] left_q,
    output logic       expire
);
    logic sec_end;

    generate
        if (TICKS_PER_SEC == 1) begin : g_direct
            assign sec_end = run && tick && !reload;
        end else begin : g_presc
            localparam int SUB_W = $clog2(TICKS_PER_SEC);
            localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);
            logic [SUB_W-1:0] sub_q;

            always_ff @(posedge clk) begin
                if (rst || reload) begin
                    sub_q <= '0;
                end else if (run && tick) begin
                    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
                end
            end
            assign sec_end = run && tick && !reload && (sub_q == SUB_LAST);
        end
    endgenerate

    assign expire = sec_end && (left_q == 8'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= DEF_TMO;
        end else if (reload || expire) begin
            left_q <= tmo;
        end else if (sec_end) begin
            left_q <= left_q - 8'd1;
        end
    end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       expire,
    input  logic       host_req,
    input  logic [7:0] width,
    output logic [7:0] cause_q,
    output logic       rst_out
);
    logic [7:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            cause_q  <= CAUSE_POWER;
        end else if (expire || host_req) begin
            remain_q <= width;
            cause_q  <= expire ? CAUSE_EXPIRY : CAUSE_HOST;
        end else if (tick && (remain_q != '0)) begin
            remain_q <= remain_q - 8'd1;
        end
    end

    assign rst_out = (remain_q != '0);
endmodule

// File: rtl/wdog_regfile_core.sv
module wdog_regfile_core
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int DEF_TIMEOUT   = 30,
    parameter int DEF_PULSE_MS  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       host_req,
    output logic       rst_out
);
    localparam logic [7:0] DEF_TMO_B   = 8'(DEF_TIMEOUT);
    localparam logic [7:0] DEF_WIDTH_B = 8'(DEF_PULSE_MS);

    reg_wr_t    wr_req;
    run_state_e st_q;
    logic [7:0] tmo_q, width_q, left_q, cause_q;
    logic       reload, expire;

    assign wr_req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    wdog_regs #(.DEF_TMO(DEF_TMO_B), .DEF_WIDTH(DEF_WIDTH_B)) u_regs (
        .clk(clk), .rst(rst), .wr(wr_req),
        .state_q(st_q), .tmo_q(tmo_q), .width_q(width_q), .reload(reload)
    );

    wdog_countdown #(.TICKS_PER_SEC(TICKS_PER_SEC), .DEF_TMO(DEF_TMO_B)) u_count (
        .clk(clk), .rst(rst), .run(st_q == ST_ON), .reload(reload),
        .tick(ms_tick), .tmo(tmo_q), .left_q(left_q), .expire(expire)
    );

    wdog_pulse_gen u_pulse (
        .clk(clk), .rst(rst), .tick(ms_tick), .expire(expire),
        .host_req(host_req), .width(width_q), .cause_q(cause_q), .rst_out(rst_out)
    );

    always_comb begin
        case (bus_addr)
            ADR_CAUSE: bus_rdata = cause_q;
            ADR_STATE: bus_rdata = st_q;
            ADR_TMO:   bus_rdata = tmo_q;
            ADR_LEFT:  bus_rdata = left_q;
            ADR_WIDTH: bus_rdata = width_q;
            default:   bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdog_regfile_core_chk.sv
module wdog_regfile_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       rst_out,
    input logic [7:0] st_q,
    input logic [7:0] tmo_q,
    input logic [7:0] width_q,
    input logic [7:0] left_q,
    input logic [7:0] cause_q
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (st_q == 8'h00 && cause_q == 8'h00 && !rst_out)); // R1

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        st_q <= 8'h02); // R2

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (st_q != 8'h02 && !(bus_wr && bus_addr == 8'h06 && bus_wdata == 8'h02))
        |=> $stable(left_q)); // R2

    AST_SHORT_TMO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h07 && bus_wdata < 8'd3) |=> $stable(tmo_q)); // R3

    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        left_q != 8'h00); // R4

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> (cause_q == 8'h01 || cause_q == 8'h04)); // R6

    AST_ZERO_WIDTH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h0A && bus_wdata == 8'h00) |=> $stable(width_q)); // R7

    AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (rst_out && !ms_tick) |=> rst_out); // R7
endmodule

bind wdog_regfile_core wdog_regfile_core_chk u_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rst_out(rst_out),
    .st_q(st_q), .tmo_q(tmo_q), .width_q(width_q), .left_q(left_q),
    .cause_q(cause_q)
);

// File: tb/wdog_regfile_core_tb.sv
module wdog_regfile_core_tb;
    localparam int TPS   = 4;
    localparam int DEF_T = 5;
    localparam int DEF_W = 3;

    logic       clk = 0;
    logic       rst = 1;
    logic       ms_tick = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       host_req = 0;
    logic       rst_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  tick_en = 0;
    int  phase = 0;
    bit  done = 0;

    // behavioural model state
    int m_st, m_tmo, m_w, m_left, m_sub, m_pc, m_cause;

    always #2.5 clk = ~clk;

    wdog_regfile_core #(.TICKS_PER_SEC(TPS), .DEF_TIMEOUT(DEF_T), .DEF_PULSE_MS(DEF_W)) u_dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_req(host_req), .rst_out(rst_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            5: return m_cause;
            6: return m_st;
            7: return m_tmo;
            8: return m_left;
            10: return m_w;
            default: return 0;
        endcase
    endfunction

    // reference model and per-clock comparison
    always @(posedge clk) begin
        bit load, exp_ev;
        int d;
        d = int'(bus_wdata);
        if (rst) begin
            m_st = 0; m_tmo = DEF_T; m_w = DEF_W; m_left = DEF_T;
            m_sub = 0; m_pc = 0; m_cause = 0;
        end else begin
            load = (bus_wr && bus_addr == 6 && d == 2 && m_st != 2) ||
                   (bus_wr && bus_addr == 9 && d == 0 && m_st == 2);
            exp_ev = 0;
            if (load) begin
                m_left = m_tmo; m_sub = 0;
            end else if (m_st == 2 && ms_tick) begin
                if (m_sub == TPS - 1) begin
                    m_sub = 0;
                    if (m_left == 1) begin exp_ev = 1; m_left = m_tmo; end
                    else m_left = m_left - 1;
                end else m_sub = m_sub + 1;
            end
            if (exp_ev || host_req) begin
                m_pc = m_w; m_cause = exp_ev ? 1 : 4;
            end else if (ms_tick && m_pc > 0) m_pc = m_pc - 1;
            if (bus_wr && bus_addr == 6 && (d == 1 || d == 2)) m_st = d;
            if (bus_wr && bus_addr == 7 && d >= 3) m_tmo = d;
            if (bus_wr && bus_addr == 10 && d >= 1) m_w = d;
        end
        #1;
        check(rst_out == (m_pc != 0), "R7 rst_out vs model", int'(rst_out), int'(m_pc != 0));
        check(int'(bus_rdata) == model_read(int'(bus_addr)), "R9 rdata vs model",
              int'(bus_rdata), model_read(int'(bus_addr)));
    end

    // millisecond tick every third clock
    initial begin
        forever begin
            @(negedge clk);
            ms_tick = tick_en && (phase == 2);
            phase = (phase + 1) % 3;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string req);
        @(negedge clk);
        bus_wr = 0; bus_addr = a;
        #1;
        check(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    endtask

    task automatic wait_pulse(output bit seen);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rst_out) begin seen = 1; break; end
        end
    endtask

    task automatic measure_pulse(output int ticks);
        ticks = 0;
        forever begin
            @(negedge clk); #1;
            if (!rst_out) break;
            if (ms_tick) ticks++;
        end
    endtask

    function automatic void summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        bit seen;
        int tks;
        int held;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        rd(8'h06, 0, "R1 state after reset");
        rd(8'h07, DEF_T, "R1 timeout after reset");
        rd(8'h08, DEF_T, "R1 time-left after reset");
        rd(8'h0A, DEF_W, "R1 width after reset");
        rd(8'h05, 0, "R1 cause after reset");
        check(!rst_out, "R1 rst_out after reset", int'(rst_out), 0);
        // R9 unmapped
        rd(8'h03, 0, "R9 unmapped 0x03");
        rd(8'h42, 0, "R9 unmapped 0x42");
        // R2 no counting in initial state
        tick_en = 1;
        repeat (60) @(negedge clk);
        rd(8'h08, DEF_T, "R2 frozen in initial");
        wr(8'h06, 8'h03);
        rd(8'h06, 0, "R2 illegal state ignored");
        // R3 timeout range
        wr(8'h07, 8'd2);
        rd(8'h07, DEF_T, "R3 value 2 ignored");
        wr(8'h07, 8'd0);
        rd(8'h07, DEF_T, "R3 value 0 ignored");
        wr(8'h07, 8'd255);
        rd(8'h07, 255, "R3 value 255 taken");
        wr(8'h07, 8'd3);
        rd(8'h07, 3, "R3 value 3 taken");
        // R4 enable reloads, writes to time-left ignored
        wr(8'h06, 8'h02);
        rd(8'h08, 3, "R4 reload on enable");
        wr(8'h08, 8'd77);
        rd(8'h08, m_left, "R4 write to time-left ignored");
        check(m_left != 77, "R4 time-left not 77", m_left, 3);
        // R6 expiry
        wait_pulse(seen);
        check(seen, "R6 pulse after expiry", int'(seen), 1);
        rd(8'h05, 1, "R6 cause expiry");
        measure_pulse(tks);
        check(tks == DEF_W, "R7 pulse ticks default", tks, DEF_W);
        // R7 width 1 and 0 ignored
        wr(8'h0A, 8'd0);
        rd(8'h0A, DEF_W, "R7 zero width ignored");
        wr(8'h0A, 8'd1);
        wait_pulse(seen);
        measure_pulse(tks);
        check(tks == 1, "R7 pulse ticks width 1", tks, 1);
        // R5 pings
        repeat (20) @(negedge clk);
        wr(8'h09, 8'h5A);
        held = m_left;
        rd(8'h08, held, "R5 nonzero ping ignored");
        wr(8'h07, 8'd4);
        rd(8'h08, held, "R3 new timeout leaves countdown");
        wr(8'h09, 8'h00);
        rd(8'h08, 4, "R5 ping reloads");
        // R2 off freezes, R5 ping in off ignored
        repeat (15) @(negedge clk);
        wr(8'h06, 8'h01);
        held = m_left;
        repeat (40) @(negedge clk);
        rd(8'h08, held, "R2 frozen when off");
        wr(8'h09, 8'h00);
        rd(8'h08, held, "R5 ping ignored when off");
        check(!rst_out, "R2 no pulse when off", int'(rst_out), 0);
        // R8 host request
        @(negedge clk); host_req = 1;
        @(negedge clk); host_req = 0;
        #1;
        check(rst_out, "R8 host pulse", int'(rst_out), 1);
        rd(8'h05, 4, "R8 cause host");
        // re-enable and expire again to return cause to 1
        wr(8'h06, 8'h02);
        rd(8'h08, 4, "R4 reload on re-enable");
        wait_pulse(seen);
        rd(8'h05, 1, "R6 cause expiry again");
        repeat (10) @(negedge clk);
        summary();
        $finish;
    end
endmodule